// File: doc/BRIEF.md
# Flash Write-Status Bit Generator

This block produces the status word that a dual-bank parallel NOR flash returns while an internal program or erase is running. A sequencer supplies, for each bank, a busy flag, an erase-or-program flag and bit 7 of the word being programmed. It also supplies the erase-suspend state and the sector or block that is suspended. For each read, the block decides whether the host sees array data or status. When it returns status, it produces the three status bits (polarity bit, main toggle bit, secondary toggle bit) and a ready level.

Bank membership comes from comparing the block-index bits of the read address with a boundary parameter. Reads aimed at an idle bank fall through to array data. The two toggle bits each live in their own flip-flop. A flip-flop advances once per rising edge of the read strobe, and only when its bit is defined to alternate for the current read. Address ports carry only the bits from the sector boundary upward, because nothing finer affects status.

Top module: `flash_wstat_gen`

## Requirements
- R1: After synchronous reset with no bank busy and no suspend, `ready` is 1 and `use_status` is 0. The first toggling status read after reset returns 1 on each toggle bit.
- R2: Bank 1 holds every unit whose block index (`rd_unit[UNIT_W-1:BLK_LSB-SECT_LSB]`) is at or above `SPLIT_BLK`, and bank 0 holds the rest. Status is selected (`use_status`=1) only for a read of a busy bank or of the suspended unit. Any other read selects array data.
- R3: A status read of a bank running a program returns the inverse of that bank's `prog_d7` on `st_dq7`.
- R4: A status read of a bank running an erase returns 0 on `st_dq7`. Once the bank's busy flag drops, reads of it select array data.
- R5: `st_dq6` flips once per rising edge of `rd_strobe` on a program or erase status read. A strobe held high counts as one read, and reads of an idle bank leave it unchanged.
- R6: `st_dq2` flips on each erase status read and on each read of the suspended unit. It holds its value across program status reads.
- R7: With `susp_on`=1, a read inside the suspended unit returns `use_status`=1, `st_dq7`=1 and `st_dq6`=1. The unit is a sector when `susp_blk`=0 and a block when `susp_blk`=1.
- R8: While suspended, a read of a different sector in an idle bank selects array data.
- R9: A program running in another unit during erase-suspend returns the inverted `prog_d7` on `st_dq7` and a toggling `st_dq6` when read.
- R10: `ready` is 0 whenever any bank is busy. It is 1 during erase-suspend with no program running.
- R11: A synchronous reset in the middle of an operation clears both toggle flip-flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_busy | input | 2 | Per-bank operation-in-progress flag |
| bank_erase | input | 2 | Per-bank type: 1 erase, 0 program |
| prog_d7 | input | 2 | Per-bank bit 7 of the word being programmed |
| susp_on | input | 1 | Erase-suspend active |
| susp_blk | input | 1 | Suspended unit is a block (1) or a sector (0) |
| susp_unit | input | UNIT_W | Sector-and-above address bits of the suspended unit |
| rd_unit | input | UNIT_W | Sector-and-above bits of the read address |
| rd_strobe | input | 1 | Read strobe; its rising edge marks one read |
| use_status | output | 1 | 1 selects status bits, 0 selects array data |
| st_dq7 | output | 1 | Polarity status bit |
| st_dq6 | output | 1 | Main toggle status bit |
| st_dq2 | output | 1 | Secondary toggle status bit |
| ready | output | 1 | 1 when no program or erase is running |

## Verification
The bench reads the last word of bank 0 and the first word of bank 1 while bank 1 is busy. An off-by-one boundary compare would return status for the wrong bank there. It reads an idle bank between two busy-bank reads, so a design that advances the toggle on any strobe shows a broken alternation. It holds the strobe high for several cycles, which catches level-sensitive toggling. It alternates reads inside and outside a suspended sector and block, which catches a design that decodes the suspended unit at the wrong granularity or lets program status override it. Finally, it resets mid-erase and checks that the next read restarts the alternation.

// File: rtl/flash_wstat_pkg.sv
package flash_wstat_pkg;

   // index of each toggle flip-flop in the toggle vector
   localparam int TGL_MAIN = 0;
   localparam int TGL_AUX  = 1;
   localparam int TGL_N    = 2;

   typedef struct packed {
      logic dq7;
      logic dq6;
      logic dq2;
   } stat_bits_t;

endpackage

// File: rtl/fws_addr_decode.sv
module fws_addr_decode #(
   parameter int ADDR_W    = 21,
   parameter int SECT_LSB  = 11,
   parameter int BLK_LSB   = 15,
   parameter int SPLIT_BLK = 16
) (
   input  logic [ADDR_W-SECT_LSB-1:0] rd_unit,
   input  logic [ADDR_W-SECT_LSB-1:0] susp_unit,
   input  logic                       susp_on,
   input  logic                       susp_blk,
   output logic                       rd_bank,
   output logic                       susp_hit
);
   localparam int UNIT_W = ADDR_W - SECT_LSB;
   localparam int BOFF   = BLK_LSB - SECT_LSB;
   localparam int BLK_W  = ADDR_W - BLK_LSB;

   if (SECT_LSB >= BLK_LSB) begin : g_bad_gran
      $error("sector size must be smaller than block size");
   end
   if (BLK_LSB >= ADDR_W) begin : g_bad_blk
      $error("block index needs at least one address bit");
   end
   if (SPLIT_BLK <= 0 || SPLIT_BLK >= (1 << BLK_W)) begin : g_bad_split
      $error("bank boundary must leave both banks non-empty");
   end

   logic [BLK_W-1:0] rd_blk;
   logic [BLK_W-1:0] sp_blk;
   logic             sect_eq;
   logic             blk_eq;

   assign rd_blk  = rd_unit[UNIT_W-1:BOFF];
   assign sp_blk  = susp_unit[UNIT_W-1:BOFF];
   assign rd_bank = (rd_blk >= BLK_W'(SPLIT_BLK));
   assign sect_eq = (rd_unit == susp_unit);
   assign blk_eq  = (rd_blk == sp_blk);

   always_comb begin
      susp_hit = 1'b0;
      if (susp_on) begin
         susp_hit = susp_blk ? blk_eq : sect_eq;
      end
   end
endmodule

// File: rtl/fws_toggle.sv
module fws_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic flip,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= 1'b0;
      end else if (flip) begin
         q <= ~q;
      end
   end

   // R5 / R6: a toggle bit never moves without a qualified read
   assert_hold_no_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !flip |=> $stable(q));
endmodule

// File: rtl/flash_wstat_gen.sv
module flash_wstat_gen #(
   parameter int ADDR_W    = 21,
   parameter int SECT_LSB  = 11,
   parameter int BLK_LSB   = 15,
   parameter int SPLIT_BLK = 16,
   localparam int UNIT_W   = ADDR_W - SECT_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bank_busy,
   input  logic [1:0]        bank_erase,
   input  logic [1:0]        prog_d7,
   input  logic              susp_on,
   input  logic              susp_blk,
   input  logic [UNIT_W-1:0] susp_unit,
   input  logic [UNIT_W-1:0] rd_unit,
   input  logic              rd_strobe,
   output logic              use_status,
   output logic              st_dq7,
   output logic              st_dq6,
   output logic              st_dq2,
   output logic              ready
);
   import flash_wstat_pkg::*;

   logic                rd_bank;
   logic                susp_hit;
   logic                strb_q;
   logic                rise;
   logic                sel_busy;
   logic                sel_ers;
   logic                sel_d7;
   logic                op_read;
   logic [TGL_N-1:0]    tgl_flip;
   logic [TGL_N-1:0]    tgl_q;
   stat_bits_t          st;

   fws_addr_decode #(
      .ADDR_W   (ADDR_W),
      .SECT_LSB (SECT_LSB),
      .BLK_LSB  (BLK_LSB),
      .SPLIT_BLK(SPLIT_BLK)
   ) u_dec (
      .rd_unit  (rd_unit),
      .susp_unit(susp_unit),
      .susp_on  (susp_on),
      .susp_blk (susp_blk),
      .rd_bank  (rd_bank),
      .susp_hit (susp_hit)
   );

   // one read per rising edge of the strobe
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strb_q <= 1'b0;
      end else begin
         strb_q <= rd_strobe;
      end
   end
   assign rise = rd_strobe & ~strb_q;

   assign sel_busy = bank_busy[rd_bank];
   assign sel_ers  = bank_erase[rd_bank];
   assign sel_d7   = prog_d7[rd_bank];
   // the suspended unit takes priority over any program status in its bank
   assign op_read  = sel_busy & ~susp_hit;

   assign tgl_flip[TGL_MAIN] = rise & op_read;
   assign tgl_flip[TGL_AUX]  = rise & (susp_hit | (op_read & sel_ers));

   for (genvar i = 0; i < TGL_N; i++) begin : g_tgl
      fws_toggle u_tgl (
         .clk  (clk),
         .rst_n(rst_n),
         .flip (tgl_flip[i]),
         .q    (tgl_q[i])
      );
   end

   always_comb begin
      st.dq2 = tgl_q[TGL_AUX];
      if (susp_hit) begin
         st.dq7 = 1'b1;
         st.dq6 = 1'b1;
      end else begin
         st.dq7 = sel_ers ? 1'b0 : ~sel_d7;
         st.dq6 = tgl_q[TGL_MAIN];
      end
   end

   assign use_status = susp_hit | op_read;
   assign st_dq7     = st.dq7;
   assign st_dq6     = st.dq6;
   assign st_dq2     = st.dq2;
   assign ready      = ~|bank_busy;

   assert_idle_array_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!bank_busy[rd_bank] && !susp_hit) |-> !use_status);

   assert_erase_polarity_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (use_status && !susp_hit && bank_erase[rd_bank]) |-> !st_dq7);

   assert_susp_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      susp_hit |-> (use_status && st_dq7 && st_dq6));

   assert_ready_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && use_status) |-> susp_hit);
endmodule

// File: tb/flash_wstat_gen_tb.sv
module flash_wstat_gen_tb;
   localparam int ADDR_W = 21;
   localparam int SECT_LSB = 11;
   localparam int UNIT_W = ADDR_W - SECT_LSB;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] bank_busy = '0;
   logic [1:0] bank_erase = '0;
   logic [1:0] prog_d7 = '0;
   logic susp_on = 1'b0;
   logic susp_blk = 1'b0;
   logic [UNIT_W-1:0] susp_unit = '0;
   logic [UNIT_W-1:0] rd_unit = '0;
   logic rd_strobe = 1'b0;
   logic use_status, st_dq7, st_dq6, st_dq2, ready;

   int checks = 0;
   int errors = 0;
   logic e6 = 1'b0;
   logic e2 = 1'b0;

   always #4 clk = ~clk;

   flash_wstat_gen u_dut (
      .clk(clk), .rst_n(rst_n), .bank_busy(bank_busy), .bank_erase(bank_erase),
      .prog_d7(prog_d7), .susp_on(susp_on), .susp_blk(susp_blk),
      .susp_unit(susp_unit), .rd_unit(rd_unit), .rd_strobe(rd_strobe),
      .use_status(use_status), .st_dq7(st_dq7), .st_dq6(st_dq6),
      .st_dq2(st_dq2), .ready(ready)
   );

   typedef struct packed {
      logic [1:0]  busy;
      logic [1:0]  ers;
      logic [1:0]  d7;
      logic        sus;
      logic        sblk;
      logic [20:0] saddr;
      logic [20:0] raddr;
      logic        use_e;
      logic        d7_e;
      logic [1:0]  m6;   // 0 hold, 1 flip, 2 fixed one
      logic        m2;   // 0 hold, 1 flip
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VEC [NV] = '{
      '{2'b01, 2'b00, 2'b01, 1'b0, 1'b0, 21'h000000, 21'h001234, 1'b1, 1'b0, 2'd1, 1'b0}, // R3 program bank0
      '{2'b01, 2'b00, 2'b01, 1'b0, 1'b0, 21'h000000, 21'h001234, 1'b1, 1'b0, 2'd1, 1'b0}, // R5 alternation
      '{2'b01, 2'b00, 2'b01, 1'b0, 1'b0, 21'h000000, 21'h0A0000, 1'b0, 1'b0, 2'd0, 1'b0}, // R2 idle bank
      '{2'b01, 2'b00, 2'b01, 1'b0, 1'b0, 21'h000000, 21'h001234, 1'b1, 1'b0, 2'd1, 1'b0}, // R5 idle read no flip
      '{2'b10, 2'b00, 2'b00, 1'b0, 1'b0, 21'h000000, 21'h0A0000, 1'b1, 1'b1, 2'd1, 1'b0}, // R3 program bank1
      '{2'b10, 2'b10, 2'b00, 1'b0, 1'b0, 21'h000000, 21'h0A0000, 1'b1, 1'b0, 2'd1, 1'b1}, // R4 R6 erase
      '{2'b10, 2'b10, 2'b00, 1'b0, 1'b0, 21'h000000, 21'h0A0000, 1'b1, 1'b0, 2'd1, 1'b1}, // R6 erase again
      '{2'b10, 2'b10, 2'b00, 1'b0, 1'b0, 21'h000000, 21'h001234, 1'b0, 1'b0, 2'd0, 1'b0}, // R2 other bank
      '{2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 21'h000000, 21'h0A0000, 1'b0, 1'b0, 2'd0, 1'b0}, // R4 completed
      '{2'b00, 2'b00, 2'b00, 1'b1, 1'b0, 21'h0A0800, 21'h0A0FFF, 1'b1, 1'b1, 2'd2, 1'b1}, // R7 sector hit
      '{2'b00, 2'b00, 2'b00, 1'b1, 1'b0, 21'h0A0800, 21'h0A1000, 1'b0, 1'b0, 2'd0, 1'b0}, // R8 next sector
      '{2'b00, 2'b00, 2'b00, 1'b1, 1'b1, 21'h0A0800, 21'h0A7FFF, 1'b1, 1'b1, 2'd2, 1'b1}, // R7 block hit
      '{2'b10, 2'b00, 2'b10, 1'b1, 1'b0, 21'h0A0800, 21'h0A2000, 1'b1, 1'b0, 2'd1, 1'b0}, // R9 program in suspend
      '{2'b10, 2'b00, 2'b10, 1'b1, 1'b0, 21'h0A0800, 21'h0A0800, 1'b1, 1'b1, 2'd2, 1'b1}, // R7 priority
      '{2'b10, 2'b00, 2'b10, 1'b1, 1'b0, 21'h000800, 21'h000000, 1'b0, 1'b0, 2'd0, 1'b0}, // R8 other sector
      '{2'b10, 2'b10, 2'b00, 1'b0, 1'b0, 21'h000000, 21'h07FFFF, 1'b0, 1'b0, 2'd0, 1'b0}, // R2 last of bank0
      '{2'b10, 2'b10, 2'b00, 1'b0, 1'b0, 21'h000000, 21'h080000, 1'b1, 1'b0, 2'd1, 1'b1}  // R2 first of bank1
   };

   task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic strobe_read(input int hold);
      rd_strobe = 1'b1;
      for (int k = 0; k < hold; k++) @(negedge clk);
      rd_strobe = 1'b0;
   endtask

   task automatic check_status(input logic d7e, input logic [1:0] m6);
      check(use_status == 1'b1, "R2 status select", use_status, 1);
      check(st_dq7 == d7e, "R3/R4 polarity bit", st_dq7, d7e);
      check(st_dq6 == ((m6 == 2'd2) ? 1'b1 : e6), "R5 main toggle", st_dq6,
            (m6 == 2'd2) ? 1'b1 : e6);
      check(st_dq2 == e2, "R6 aux toggle", st_dq2, e2);
   endtask

   initial begin : watchdog
      for (int c = 0; c < 100000; c++) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(ready == 1'b1, "R1 ready after reset", ready, 1);
      check(use_status == 1'b0, "R1 array select after reset", use_status, 0);

      for (int i = 0; i < NV; i++) begin
         bank_busy  = VEC[i].busy;
         bank_erase = VEC[i].ers;
         prog_d7    = VEC[i].d7;
         susp_on    = VEC[i].sus;
         susp_blk   = VEC[i].sblk;
         susp_unit  = VEC[i].saddr[20:11];
         rd_unit    = VEC[i].raddr[20:11];
         rd_strobe  = 1'b1;
         @(negedge clk);
         if (VEC[i].use_e) begin
            if (VEC[i].m6 == 2'd1) e6 = ~e6;
            if (VEC[i].m2) e2 = ~e2;
            check_status(VEC[i].d7_e, VEC[i].m6);
         end else begin
            check(use_status == 1'b0, "R2/R8 array select", use_status, 0);
         end
         check(ready == ~|VEC[i].busy, "R10 ready level", ready, ~|VEC[i].busy);
         rd_strobe = 1'b0;
         @(negedge clk);
      end

      // R10: suspend with no program reads ready
      bank_busy = 2'b00; susp_on = 1'b1;
      @(negedge clk);
      check(ready == 1'b1, "R10 ready in suspend", ready, 1);
      susp_on = 1'b0;

      // R5: held strobe counts as one read
      bank_busy = 2'b10; bank_erase = 2'b10; rd_unit = 10'h140;
      strobe_read(4);
      e6 = ~e6; e2 = ~e2;
      check(st_dq6 == e6, "R5 held strobe single flip", st_dq6, e6);
      check(st_dq2 == e2, "R6 held strobe single flip", st_dq2, e2);
      @(negedge clk);

      // R6: program reads hold the aux toggle
      bank_erase = 2'b00;
      strobe_read(1);
      e6 = ~e6;
      check(st_dq2 == e2, "R6 aux hold in program", st_dq2, e2);
      @(negedge clk);
      strobe_read(1);
      e6 = ~e6;
      check(st_dq2 == e2, "R6 aux hold in program", st_dq2, e2);
      check(st_dq6 == e6, "R5 main toggle program", st_dq6, e6);
      @(negedge clk);

      // R11: mid-operation reset clears both toggles
      bank_erase = 2'b10;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      e6 = 1'b0; e2 = 1'b0;
      @(negedge clk);
      strobe_read(1);
      check(st_dq6 == 1'b1, "R11 main toggle restarts", st_dq6, 1);
      check(st_dq2 == 1'b1, "R11 aux toggle restarts", st_dq2, 1);
      check(ready == 1'b0, "R10 busy after reset", ready, 0);
      @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule